// File: doc/BRIEF.md
# Single-Address DMA Channel Sequencer

This block is one DMA channel that moves data between an external peripheral and ordinary external memory without holding the data itself. The channel drives the memory address, chip select and one strobe. It also pulls an active-low acknowledge to the peripheral. The peripheral then sources or sinks the data directly on the shared data bus. Software-side configuration arrives as plain inputs: start address, unit count, unit size, direction and bus-hold policy. A one-cycle `start` pulse arms the channel.

After arming, the channel waits for the peripheral's active-low level request. It then raises a bus request to a simple arbiter and performs transfers only once grant is seen. The hold policy decides when the bus is released. In steal mode the channel releases the bus after every unit and arbitrates again on the next request. In hold mode it keeps the bus across the whole block. A sixteen-byte unit is carried out as four consecutive longword bus cycles. A one-cycle `done` pulse marks the end of the block.

Top module: `sadma_channel`

## Requirements
- R1: While reset is high, and in the cycle after it, `bus_req` and `done` are 0 and `mem_cs_n`, `mem_rd_n`, `mem_wr_n` and `dack_n` are 1.
- R2: A `start` pulse in the idle state latches the configuration. If `cfg_count` is 0, no bus request is made, and `done` is 1 in the following cycle only.
- R3: Once armed, a low `dreq_n` sampled at a clock edge raises `bus_req` after that edge. `mem_cs_n`, the strobes and `dack_n` stay high until `bus_gnt` has been sampled high.
- R4: In every transfer cycle, `mem_cs_n` and `dack_n` are 0 together. With `cfg_dir`=0 (peripheral to memory) only `mem_wr_n` is 0. With `cfg_dir`=1 (memory to peripheral) only `mem_rd_n` is 0.
- R5: The unit-size code is 0 for byte, 1 for word (2 bytes), 2 for longword (4 bytes) and 3 for sixteen bytes. After each unit the address advances by the unit's byte size.
- R6: A sixteen-byte unit takes four back-to-back bus cycles at address offsets +0, +4, +8 and +12, with `dack_n` low in all four.
- R7: With `cfg_burst`=0, each unit is followed by one cycle with all outputs inactive and `bus_req` still 1. `bus_req` is 0 in the cycle after that. The next unit starts only after a fresh low `dreq_n`.
- R8: With `cfg_burst`=1, units follow each other with no idle cycle and without re-sampling `dreq_n`. `bus_req` falls exactly once per block.
- R9: The remaining count drops by one per unit. `done` pulses for exactly one cycle, in the cycle where `bus_req` falls after the last unit.
- R10: A `start` pulse while a block is in progress is ignored: the running block's addresses and unit count are unchanged.
- R11: `bus_req` never falls in a cycle that follows one with `mem_cs_n` or `dack_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that arms the channel |
| cfg_addr | input | AW | Start address in memory |
| cfg_count | input | CW | Number of units to transfer |
| cfg_unit | input | 2 | Unit size code (0 byte, 1 word, 2 longword, 3 sixteen bytes) |
| cfg_dir | input | 1 | 0 peripheral to memory (write), 1 memory to peripheral (read) |
| cfg_burst | input | 1 | 0 release bus after each unit, 1 hold bus for the block |
| dreq_n | input | 1 | Active-low level transfer request from the peripheral |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| mem_addr | output | AW | Memory address, 0 outside transfer cycles |
| mem_cs_n | output | 1 | Active-low memory chip select |
| mem_rd_n | output | 1 | Active-low memory read strobe |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| dack_n | output | 1 | Active-low acknowledge to the peripheral |
| done | output | 1 | One-cycle pulse at block end |

## Verification
Assertions check several properties on every cycle:
- chip select only ever appears under grant, together with acknowledge and exactly one strobe;
- the bus is never dropped straight out of a transfer cycle;
- the sixteen-byte beats step by four bytes;
- hold mode chains units;
- `done` never lasts two cycles.

Other behaviours depend on whole sequences, and only the bench's scenarios can show them. These are the address advance for each unit size, the exact count of units, and the single bus release in hold mode against one release per unit in steal mode. The same holds for re-arbitration gated by the request level, the count-zero shortcut and a start pulse ignored mid-block. The bench shows these by comparing the ports cycle by cycle against a behavioural model under varied grant latency and request gaps.

// File: rtl/sadma_pkg.sv
package sadma_pkg;

    typedef enum logic [1:0] {
        UNIT_B = 2'd0,
        UNIT_W = 2'd1,
        UNIT_L = 2'd2,
        UNIT_Q = 2'd3
    } unit_e;

    typedef enum logic {
        DIR_P2M = 1'b0,
        DIR_M2P = 1'b1
    } dir_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_ARB,
        ST_MOVE,
        ST_FREE
    } state_e;

    localparam int QUAD_BEATS = 4;
    localparam int BEAT_BYTES = 4;

    function automatic logic [4:0] unit_bytes(input unit_e u);
        case (u)
            UNIT_B:  return 5'd1;
            UNIT_W:  return 5'd2;
            UNIT_L:  return 5'd4;
            default: return 5'(QUAD_BEATS * BEAT_BYTES);
        endcase
    endfunction

endpackage

// File: rtl/sadma_addr_gen.sv
module sadma_addr_gen
    import sadma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  unit_e         cfg_unit,
    input  dir_e          cfg_dir,
    input  logic          cfg_burst,
    output logic [AW-1:0] bus_addr,
    output logic          beat_last,
    output logic          final_unit,
    output logic          cnt_zero,
    output dir_e          dir_q,
    output logic          burst_q
);
    localparam int BW = $clog2(QUAD_BEATS);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic [BW-1:0] beat_q;
    unit_e         unit_q;

    assign beat_last  = (unit_q != UNIT_Q) || (beat_q == BW'(QUAD_BEATS - 1));
    assign final_unit = beat_last && (cnt_q == CW'(1));
    assign cnt_zero   = (cnt_q == '0);
    assign bus_addr   = addr_q + AW'(beat_q) * AW'(BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            cnt_q   <= '0;
            beat_q  <= '0;
            unit_q  <= UNIT_B;
            dir_q   <= DIR_P2M;
            burst_q <= 1'b0;
        end else if (load) begin
            addr_q  <= cfg_addr;
            cnt_q   <= cfg_count;
            beat_q  <= '0;
            unit_q  <= cfg_unit;
            dir_q   <= cfg_dir;
            burst_q <= cfg_burst;
        end else if (step) begin
            if (beat_last) begin
                beat_q <= '0;
                addr_q <= addr_q + AW'(unit_bytes(unit_q));
                cnt_q  <= cnt_q - CW'(1);
            end else begin
                beat_q <= beat_q + BW'(1);
            end
        end
    end

    // R6: inner beats of a sixteen-byte unit step by one longword
    assert_quad_step_R6: assert property (@(posedge clk) disable iff (rst)
        (step && unit_q == UNIT_Q && beat_q != '0) |-> bus_addr == $past(bus_addr) + AW'(BEAT_BYTES));

endmodule

// File: rtl/sadma_seq.sv
module sadma_seq
    import sadma_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   cfg_cnt_zero,
    input  logic   dreq_n,
    input  logic   bus_gnt,
    input  logic   beat_last,
    input  logic   final_unit,
    input  logic   cnt_zero,
    input  logic   burst,
    output state_e state,
    output logic   load,
    output logic   done
);
    state_e nxt;

    assign load = (state == ST_IDLE) && start && !cfg_cnt_zero;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (load) nxt = ST_ARMED;
            ST_ARMED: if (!dreq_n) nxt = ST_ARB;
            ST_ARB:   if (bus_gnt) nxt = ST_MOVE;
            ST_MOVE:  if (beat_last && (final_unit || !burst)) nxt = ST_FREE;
            ST_FREE:  nxt = cnt_zero ? ST_IDLE : ST_ARMED;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= nxt;
            done  <= ((state == ST_IDLE) && start && cfg_cnt_zero) ||
                     ((state == ST_FREE) && cnt_zero);
        end
    end

    // R9: completion is a single-cycle pulse
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: hold mode chains units with no gap
    assert_burst_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MOVE && burst && beat_last && !final_unit) |=> state == ST_MOVE);

endmodule

// File: rtl/sadma_pins.sv
module sadma_pins
    import sadma_pkg::*;
#(
    parameter int AW = 32
) (
    input  state_e        state,
    input  dir_e          dir,
    input  logic [AW-1:0] bus_addr,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          dack_n
);
    logic moving;

    assign moving   = (state == ST_MOVE);
    assign bus_req  = (state == ST_ARB) || moving || (state == ST_FREE);
    assign mem_addr = moving ? bus_addr : '0;
    assign mem_cs_n = !moving;
    assign dack_n   = !moving;
    assign mem_wr_n = !(moving && dir == DIR_P2M);
    assign mem_rd_n = !(moving && dir == DIR_M2P);

endmodule

// File: rtl/sadma_channel.sv
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic [1:0]    cfg_unit,
    input  logic          cfg_dir,
    input  logic          cfg_burst,
    input  logic          dreq_n,
    input  logic          bus_gnt,
    output logic          bus_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          dack_n,
    output logic          done
);
    state_e        state;
    logic          load, beat_last, final_unit, cnt_zero, burst_q;
    dir_e          dir_q;
    logic [AW-1:0] bus_addr;

    sadma_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .step       (state == ST_MOVE),
        .cfg_addr   (cfg_addr),
        .cfg_count  (cfg_count),
        .cfg_unit   (unit_e'(cfg_unit)),
        .cfg_dir    (dir_e'(cfg_dir)),
        .cfg_burst  (cfg_burst),
        .bus_addr   (bus_addr),
        .beat_last  (beat_last),
        .final_unit (final_unit),
        .cnt_zero   (cnt_zero),
        .dir_q      (dir_q),
        .burst_q    (burst_q)
    );

    sadma_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cfg_cnt_zero (cfg_count == '0),
        .dreq_n       (dreq_n),
        .bus_gnt      (bus_gnt),
        .beat_last    (beat_last),
        .final_unit   (final_unit),
        .cnt_zero     (cnt_zero),
        .burst        (burst_q),
        .state        (state),
        .load         (load),
        .done         (done)
    );

    sadma_pins #(.AW(AW)) u_pins (
        .state    (state),
        .dir      (dir_q),
        .bus_addr (bus_addr),
        .bus_req  (bus_req),
        .mem_addr (mem_addr),
        .mem_cs_n (mem_cs_n),
        .mem_rd_n (mem_rd_n),
        .mem_wr_n (mem_wr_n),
        .dack_n   (dack_n)
    );

    // R3: memory is only selected while grant is held
    assert_cs_under_grant_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> bus_gnt);

    // R4: select, acknowledge and exactly one strobe move together
    assert_ack_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> (!dack_n && (mem_rd_n != mem_wr_n)));

    // R7: a transfer burst ends with one release cycle before the request drops
    assert_release_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (bus_req ##1 !bus_req));

    // R11: request never falls straight out of a driven cycle
    assert_release_order_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(mem_cs_n && dack_n));

endmodule

// File: tb/sadma_channel_bench.sv
module sadma_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [7:0]  cfg_count = '0;
    logic [1:0]  cfg_unit = '0;
    logic        cfg_dir = 1'b0;
    logic        cfg_burst = 1'b0;
    logic        dreq_n;
    logic        bus_gnt = 1'b0;
    logic        bus_req;
    logic [31:0] mem_addr;
    logic        mem_cs_n, mem_rd_n, mem_wr_n, dack_n, done;

    always #2 clk = ~clk;

    sadma_channel u_sadma_channel (
        .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_unit(cfg_unit), .cfg_dir(cfg_dir),
        .cfg_burst(cfg_burst), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .dack_n(dack_n), .done(done)
    );

    int    tests = 0;
    int    fails = 0;
    bit    finished = 0;
    string tag = "R1";

    // ---------------- peripheral and arbiter models ----------------
    int req_total = 0;
    int served = 0;
    int hold = 0;
    int gap_cfg = 0;
    int gnt_lat = 0;
    int wait_c = 0;
    bit prev_dack = 1'b1;
    bit prev_req = 1'b0;
    int done_cnt = 0;
    int fall_cnt = 0;

    assign dreq_n = !((served < req_total) && (hold == 0));

    always @(posedge clk) begin
        if (!prev_dack && dack_n) begin
            served <= served + 1;
            hold   <= gap_cfg;
        end else if (hold > 0) begin
            hold <= hold - 1;
        end
        prev_dack <= dack_n;
        prev_req  <= bus_req;
        if (prev_req && !bus_req) fall_cnt <= fall_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            wait_c  <= 0;
        end else if (wait_c >= gnt_lat) begin
            bus_gnt <= 1'b1;
        end else begin
            wait_c <= wait_c + 1;
        end
    end

    // ---------------- behavioural reference ----------------
    int          ms = 0;      // 0 idle, 1 armed, 2 waiting grant, 3 moving, 4 releasing
    int          mc = 0;
    int          mbeat = 0;
    int          munit = 0;
    bit          mdir = 0, mburst = 0, mdone = 0;
    logic [31:0] ma = '0;

    function automatic int bytes_of(input int u);
        return (u == 3) ? 16 : (1 << u);
    endfunction

    always @(posedge clk) begin
        mdone = 0;
        if (rst) begin
            ms = 0; mc = 0; mbeat = 0; ma = '0;
        end else begin
            case (ms)
                0: if (start) begin
                       if (cfg_count == 0) mdone = 1;
                       else begin
                           ma = cfg_addr; mc = cfg_count; munit = cfg_unit;
                           mdir = cfg_dir; mburst = cfg_burst; mbeat = 0; ms = 1;
                       end
                   end
                1: if (!dreq_n) ms = 2;
                2: if (bus_gnt) ms = 3;
                3: begin
                       if (mbeat == ((munit == 3) ? 3 : 0)) begin
                           mbeat = 0;
                           ma = ma + 32'(bytes_of(munit));
                           mc = mc - 1;
                           if (mc == 0 || !mburst) ms = 4;
                       end else mbeat = mbeat + 1;
                   end
                4: if (mc == 0) begin ms = 0; mdone = 1; end else ms = 1;
                default: ms = 0;
            endcase
        end
    end

    task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!finished) begin
            check(tag, "bus_req", 32'(bus_req), 32'(ms >= 2));
            check(tag, "mem_cs_n", 32'(mem_cs_n), 32'(ms != 3));
            check(tag, "dack_n", 32'(dack_n), 32'(ms != 3));
            check(tag, "mem_wr_n", 32'(mem_wr_n), 32'(!(ms == 3 && !mdir)));
            check(tag, "mem_rd_n", 32'(mem_rd_n), 32'(!(ms == 3 && mdir)));
            check(tag, "mem_addr", mem_addr, (ms == 3) ? ma + 32'(4 * mbeat) : 32'h0);
            check(tag, "done", 32'(done), 32'(mdone));
        end
    end

    // ---------------- scenarios ----------------
    task automatic launch(input logic [31:0] a, input int c, input int u,
                          input bit d, input bit b, input int reqs);
        @(negedge clk);
        cfg_addr = a; cfg_count = 8'(c); cfg_unit = 2'(u);
        cfg_dir = d; cfg_burst = b; start = 1'b1;
        req_total = req_total + reqs;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        int n = 0;
        while (done_cnt == d0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        tests++;
        if (done_cnt == d0) begin
            fails++;
            $display("FAIL %s done: actual none expected pulse", tag);
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input string t, input logic [31:0] a, input int c, input int u,
                       input bit d, input bit b, input int gap, input int lat, input int exp_falls);
        int d0, f0;
        tag = t; gap_cfg = gap; gnt_lat = lat;
        d0 = done_cnt; f0 = fall_cnt;
        launch(a, c, u, d, b, (c == 0) ? 0 : (b ? 1 : c));
        wait_done(d0);
        check(t, "done count", 32'(done_cnt - d0), 32'd1);
        check(t, "bus_req falls", 32'(fall_cnt - f0), 32'(exp_falls));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "bus_req in reset", 32'(bus_req), 32'd0);
        check("R1", "strobes in reset", {28'd0, mem_cs_n, mem_rd_n, mem_wr_n, dack_n}, 32'hF);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", 32'(done), 32'd0);

        run("R4_R5_byte_write", 32'h1000, 3, 0, 1'b0, 1'b0, 4, 0, 3);
        run("R4_R5_word_read", 32'h2002, 2, 1, 1'b1, 1'b0, 0, 2, 2);
        run("R3_R7_long_steal_lat", 32'h3000, 3, 2, 1'b0, 1'b0, 2, 5, 3);
        run("R6_quad_steal", 32'h4000, 2, 3, 1'b1, 1'b0, 1, 1, 2);
        run("R8_R11_long_burst", 32'h5000, 4, 2, 1'b0, 1'b1, 0, 3, 1);
        run("R8_R6_quad_burst", 32'h6000, 2, 3, 1'b1, 1'b1, 0, 0, 1);
        run("R2_count_zero", 32'h7000, 0, 2, 1'b0, 1'b0, 0, 0, 0);
        run("R9_single_unit", 32'h8000, 1, 0, 1'b1, 1'b0, 0, 0, 1);

        // R10: restart attempt mid-block must not disturb the running block
        begin
            int d0, f0;
            tag = "R10_restart_ignored"; gap_cfg = 6; gnt_lat = 1;
            d0 = done_cnt; f0 = fall_cnt;
            launch(32'h9000, 3, 1, 1'b0, 1'b0, 3);
            repeat (8) @(negedge clk);
            cfg_addr = 32'hA000; cfg_count = 8'd9; cfg_unit = 2'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(d0);
            check(tag, "done count", 32'(done_cnt - d0), 32'd1);
            check(tag, "bus_req falls", 32'(fall_cnt - f0), 32'd3);
            repeat (20) @(negedge clk);
            check(tag, "idle after block", 32'(bus_req), 32'd0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule